// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block carries out the processor-side bookkeeping when the core accepts an exception or a hardware interrupt. On a one-cycle accept strobe it looks at the pending exception (with its 12-bit event code), the interrupt request and the vector offered by an external interrupt controller. It then decides whether an entry takes place and which handler runs. In the same step it computes the new program counter, status word and saved-context registers.

The core supplies the current status word, program counter, stack register, vector base and the sleep and delay-slot flags. The block holds the resulting architectural values in registers and raises a one-cycle done pulse in the cycle they commit. That pulse also tells the core to clear its sleep flag and its delay-slot flags. Status word layout: block bit 28, privileged-mode bit 30, register-bank bit 29, FPU-disable bit 15, interrupt mask bits 7:4.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the PC output is 0xA0000000, the SR output is 0x70000000 (block, mode and bank bits set), SSR, SPC, SGR, EXPEVT and INTEVT read zero, and done is low.
- R2: When an exception and an interrupt are both requested, only the exception is taken: EXPEVT gets the code and INTEVT keeps its previous value.
- R3: On every entry SSR takes the incoming SR, SGR takes the incoming R15, and the new SR is the incoming SR with bits 28, 29 and 30 set.
- R4: With SR bit 28 set, an exception whose code is not 0x1E0 is taken as code 0x000; code 0x1E0 keeps its own code.
- R5: With SR bit 28 set, an interrupt request causes no entry (no done, outputs unchanged) unless the sleep flag is set.
- R6: SPC takes the incoming PC, reduced by 2 when the delay-slot flag is set.
- R7: Exception codes 0x000, 0x020 and 0x140 clear SR bit 15, force SR bits 7:4 to 0xF and set PC to 0xA0000000.
- R8: Exception codes 0x040 and 0x060 set PC to VBR+0x400; every other exception sets PC to VBR+0x100; code 0x160 adds 2 to SPC.
- R9: The mask output always equals SR bits 7:4; an accepted interrupt with no valid vector causes no entry, otherwise INTEVT takes the vector and PC becomes VBR+0x600.
- R10: Done pulses for exactly one cycle, in the cycle after an accept strobe that leads to an entry; without the strobe no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| acceptStb | input | 1 | One-cycle strobe: evaluate pending events now |
| excReq | input | 1 | An exception is pending |
| excCode | input | 12 | Event code of the pending exception |
| irqReq | input | 1 | A hardware interrupt is pending |
| irqMask | output | 4 | Current mask sent to the interrupt controller |
| irqVecValid | input | 1 | Controller has a vector above the mask |
| irqVec | input | 12 | Vector reported by the controller |
| srIn | input | 32 | Current status word |
| pcIn | input | 32 | Current program counter |
| r15In | input | 32 | Current stack register |
| vbrIn | input | 32 | Vector base |
| sleepIn | input | 1 | Core is sleeping |
| inSlot | input | 1 | Event hit inside a delay slot |
| pcOut | output | 32 | Handler PC |
| srOut | output | 32 | Updated status word |
| ssrOut | output | 32 | Saved status word |
| spcOut | output | 32 | Saved PC |
| sgrOut | output | 32 | Saved stack register |
| expevtOut | output | 12 | Last exception code |
| intevtOut | output | 12 | Last interrupt vector |
| entryDone | output | 1 | Entry committed this cycle |

## Verification
The bench sweeps every handler-class exception code against the block bit and the delay-slot flag, and every block/sleep/vector combination for interrupts. It goes after the blocked case: a design that forgets the 0x1E0 exemption sends that event to the reset vector, and one that drops the sleep exception loses wake-up interrupts. It also targets the combined trap-in-slot case, where a wrong SPC sum rewinds by 4 or not at all, and the simultaneous request case, where a design without priority overwrites INTEVT.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int CODE_W   = 12;
  localparam int MASK_W   = 4;
  localparam int SR_FD    = 15;
  localparam int SR_BL    = 28;
  localparam int SR_RB    = 29;
  localparam int SR_MD    = 30;
  localparam int MASK_LO  = 4;

  localparam logic [CODE_W-1:0] EV_POWER   = 12'h000;
  localparam logic [CODE_W-1:0] EV_MANUAL  = 12'h020;
  localparam logic [CODE_W-1:0] EV_MULTI   = 12'h140;
  localparam logic [CODE_W-1:0] EV_MISS_RD = 12'h040;
  localparam logic [CODE_W-1:0] EV_MISS_WR = 12'h060;
  localparam logic [CODE_W-1:0] EV_TRAP    = 12'h160;
  localparam logic [CODE_W-1:0] EV_UNMASK  = 12'h1E0;

  typedef struct packed {
    logic              take;
    logic              isExc;
    logic              isIrq;
    logic              resetClass;
    logic              missClass;
    logic              trapAdj;
    logic              rewind;
    logic [CODE_W-1:0] code;
  } entry_ctl_t;
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic              acceptStb,
  input  logic              excReq,
  input  logic [CODE_W-1:0] excCode,
  input  logic              irqReq,
  input  logic              irqVecValid,
  input  logic              blocked,
  input  logic              sleepIn,
  input  logic              inSlot,
  output entry_ctl_t        ctl
);
  logic              wantIrq;
  logic              irqOk;
  logic [CODE_W-1:0] effCode;

  always_comb begin
    effCode = excCode;
    if (blocked && (excCode != EV_UNMASK)) effCode = EV_POWER;
    wantIrq = irqReq && !excReq;
    irqOk   = wantIrq && (!blocked || sleepIn) && irqVecValid;

    ctl            = '0;
    ctl.isExc      = acceptStb && excReq;
    ctl.isIrq      = acceptStb && irqOk;
    ctl.take       = ctl.isExc || ctl.isIrq;
    ctl.code       = effCode;
    ctl.resetClass = (effCode == EV_POWER) || (effCode == EV_MANUAL) ||
                     (effCode == EV_MULTI);
    ctl.missClass  = (effCode == EV_MISS_RD) || (effCode == EV_MISS_WR);
    ctl.trapAdj    = (effCode == EV_TRAP);
    ctl.rewind     = inSlot;
  end
endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'hA000_0000,
  parameter logic [ADDR_W-1:0] OFS_GEN  = 32'h0000_0100,
  parameter logic [ADDR_W-1:0] OFS_MISS = 32'h0000_0400,
  parameter logic [ADDR_W-1:0] OFS_IRQ  = 32'h0000_0600
) (
  input  logic              clk,
  input  logic              rstN,
  input  entry_ctl_t        ctl,
  input  logic [ADDR_W-1:0] srIn,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] r15In,
  input  logic [ADDR_W-1:0] vbrIn,
  input  logic [CODE_W-1:0] irqVec,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] srOut,
  output logic [ADDR_W-1:0] ssrOut,
  output logic [ADDR_W-1:0] spcOut,
  output logic [ADDR_W-1:0] sgrOut,
  output logic [CODE_W-1:0] expevtOut,
  output logic [CODE_W-1:0] intevtOut,
  output logic              entryDone
);
  localparam logic [ADDR_W-1:0] PRIV_BITS =
    (ADDR_W'(1) << SR_BL) | (ADDR_W'(1) << SR_MD) | (ADDR_W'(1) << SR_RB);
  localparam logic [ADDR_W-1:0] SLOT_STEP = ADDR_W'(2);

  logic [ADDR_W-1:0] srNext, pcNext, spcNext;

  always_comb begin
    srNext = srIn | PRIV_BITS;
    if (ctl.isExc && ctl.resetClass) begin
      srNext[SR_FD] = 1'b0;
      srNext[MASK_LO +: MASK_W] = '1;
    end
    spcNext = pcIn;
    if (ctl.rewind) spcNext = spcNext - SLOT_STEP;
    if (ctl.isExc && ctl.trapAdj) spcNext = spcNext + SLOT_STEP;
    if (ctl.isExc) begin
      if (ctl.resetClass)     pcNext = RESET_PC;
      else if (ctl.missClass) pcNext = vbrIn + OFS_MISS;
      else                    pcNext = vbrIn + OFS_GEN;
    end else begin
      pcNext = vbrIn + OFS_IRQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcOut     <= RESET_PC;
      srOut     <= PRIV_BITS;
      ssrOut    <= '0;
      spcOut    <= '0;
      sgrOut    <= '0;
      expevtOut <= '0;
      intevtOut <= '0;
      entryDone <= 1'b0;
    end else begin
      entryDone <= ctl.take;
      if (ctl.take) begin
        pcOut  <= pcNext;
        srOut  <= srNext;
        ssrOut <= srIn;
        spcOut <= spcNext;
        sgrOut <= r15In;
        if (ctl.isExc) expevtOut <= ctl.code;
        if (ctl.isIrq) intevtOut <= irqVec;
      end
    end
  end

  AST_PRIV_SET: assert property (@(posedge clk) disable iff (!rstN)
    entryDone |-> (srOut[SR_BL] && srOut[SR_MD] && srOut[SR_RB])); // R3
  AST_SAVE_CTX: assert property (@(posedge clk) disable iff (!rstN)
    entryDone |-> (ssrOut == $past(srIn) && sgrOut == $past(r15In))); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !entryDone |-> $stable(pcOut)); // R10
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        acceptStb,
  input  logic        excReq,
  input  logic [11:0] excCode,
  input  logic        irqReq,
  output logic [3:0]  irqMask,
  input  logic        irqVecValid,
  input  logic [11:0] irqVec,
  input  logic [31:0] srIn,
  input  logic [31:0] pcIn,
  input  logic [31:0] r15In,
  input  logic [31:0] vbrIn,
  input  logic        sleepIn,
  input  logic        inSlot,
  output logic [31:0] pcOut,
  output logic [31:0] srOut,
  output logic [31:0] ssrOut,
  output logic [31:0] spcOut,
  output logic [31:0] sgrOut,
  output logic [11:0] expevtOut,
  output logic [11:0] intevtOut,
  output logic        entryDone
);
  entry_ctl_t ctl;

  assign irqMask = srIn[MASK_LO +: MASK_W];

  exc_entry_ctrl u_ctrl (
    .acceptStb  (acceptStb),
    .excReq     (excReq),
    .excCode    (excCode),
    .irqReq     (irqReq),
    .irqVecValid(irqVecValid),
    .blocked    (srIn[SR_BL]),
    .sleepIn    (sleepIn),
    .inSlot     (inSlot),
    .ctl        (ctl)
  );

  exc_entry_dp #(.ADDR_W(32)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .srIn     (srIn),
    .pcIn     (pcIn),
    .r15In    (r15In),
    .vbrIn    (vbrIn),
    .irqVec   (irqVec),
    .pcOut    (pcOut),
    .srOut    (srOut),
    .ssrOut   (ssrOut),
    .spcOut   (spcOut),
    .sgrOut   (sgrOut),
    .expevtOut(expevtOut),
    .intevtOut(intevtOut),
    .entryDone(entryDone)
  );

  AST_DONE_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    entryDone |-> $past(acceptStb)); // R10
  AST_BLOCKED_EXC_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $past(acceptStb && excReq && srIn[SR_BL] && excCode != EV_UNMASK)
      |-> (entryDone && expevtOut == EV_POWER && pcOut == 32'hA000_0000)); // R4
  AST_BLOCKED_IRQ_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    $past(acceptStb && !excReq && irqReq && srIn[SR_BL] && !sleepIn)
      |-> !entryDone); // R5
  AST_EXC_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (entryDone && $past(excReq)) |-> (intevtOut == $past(intevtOut))); // R2
  AST_NO_VECTOR_NO_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $past(acceptStb && !excReq && irqReq && !irqVecValid) |-> !entryDone); // R9
endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        acceptStb = 1'b0, excReq = 1'b0, irqReq = 1'b0;
  logic [11:0] excCode = '0, irqVec = '0;
  logic        irqVecValid = 1'b0, sleepIn = 1'b0, inSlot = 1'b0;
  logic [31:0] srIn = '0, pcIn = '0, r15In = '0, vbrIn = 32'h8C00_0000;
  logic [3:0]  irqMask;
  logic [31:0] pcOut, srOut, ssrOut, spcOut, sgrOut;
  logic [11:0] expevtOut, intevtOut;
  logic        entryDone;

  int checks = 0, failures = 0;
  logic [31:0] ePc = 32'hA000_0000, eSr = 32'h7000_0000, eSsr = 0, eSpc = 0, eSgr = 0;
  logic [11:0] eExp = 0, eInt = 0;

  always #4 clk = ~clk;

  exc_entry_seq u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cmpAll(input string req);
    chk(pcOut == ePc, req, "pc", pcOut, ePc);
    chk(srOut == eSr, req, "sr", srOut, eSr);
    chk(ssrOut == eSsr, req, "ssr", ssrOut, eSsr);
    chk(spcOut == eSpc, req, "spc", spcOut, eSpc);
    chk(sgrOut == eSgr, req, "sgr", sgrOut, eSgr);
    chk(expevtOut == eExp, req, "expevt", {20'h0, expevtOut}, {20'h0, eExp});
    chk(intevtOut == eInt, req, "intevt", {20'h0, intevtOut}, {20'h0, eInt});
  endtask

  task automatic runEvent(input logic stb, input logic exc, input logic [11:0] code,
                          input logic irq, input logic vv, input logic [11:0] vec,
                          input logic [31:0] sr, input logic [31:0] pc,
                          input logic [31:0] r15, input logic sl, input logic slot,
                          input string req);
    logic blk, takeE, takeI;
    logic [11:0] ec;
    blk   = sr[28];
    ec    = (blk && code != 12'h1E0) ? 12'h000 : code;
    takeE = stb && exc;
    takeI = stb && !exc && irq && (!blk || sl) && vv;
    if (takeE || takeI) begin
      eSsr = sr;
      eSgr = r15;
      eSpc = pc - (slot ? 32'd2 : 32'd0) + ((takeE && ec == 12'h160) ? 32'd2 : 32'd0);
      eSr  = sr | 32'h7000_0000;
      if (takeE) begin
        eExp = ec;
        if (ec == 12'h000 || ec == 12'h020 || ec == 12'h140) begin
          eSr[15] = 1'b0;
          eSr[7:4] = 4'hF;
          ePc = 32'hA000_0000;
        end else if (ec == 12'h040 || ec == 12'h060) ePc = vbrIn + 32'h400;
        else ePc = vbrIn + 32'h100;
      end else begin
        eInt = vec;
        ePc  = vbrIn + 32'h600;
      end
    end
    @(negedge clk);
    acceptStb = stb; excReq = exc; excCode = code; irqReq = irq;
    irqVecValid = vv; irqVec = vec; srIn = sr; pcIn = pc; r15In = r15;
    sleepIn = sl; inSlot = slot;
    #1;
    chk(irqMask == sr[7:4], "R9", "mask", {28'h0, irqMask}, {28'h0, sr[7:4]});
    @(negedge clk);
    acceptStb = 1'b0; excReq = 1'b0; irqReq = 1'b0;
    chk(entryDone == (takeE || takeI), req, "done", {31'h0, entryDone},
        {31'h0, takeE || takeI});
    cmpAll(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [11:0] codes [13];
    codes = '{12'h000, 12'h020, 12'h040, 12'h060, 12'h080, 12'h0A0, 12'h0E0,
              12'h100, 12'h140, 12'h160, 12'h180, 12'h1E0, 12'h800};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(entryDone == 1'b0, "R1", "done", {31'h0, entryDone}, 32'h0);
    cmpAll("R1");
    rstN = 1'b1;

    // R3 R4 R6 R7 R8: exception sweep over codes, block bit, delay slot
    for (int c = 0; c < 13; c++)
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < 2; s++)
          runEvent(1'b1, 1'b1, codes[c], 1'b0, 1'b0, 12'h0,
                   (b != 0) ? 32'h1000_80A0 : 32'h0000_8030,
                   32'h0C00_1000 + {20'h0, codes[c]}, 32'h0CFF_F000 + 32'(c),
                   1'b0, s[0], (b != 0) ? "R4" : ((s != 0) ? "R6" : "R8"));

    // R5 R9: interrupt sweep over block, sleep, vector valid
    for (int b = 0; b < 2; b++)
      for (int sl = 0; sl < 2; sl++)
        for (int v = 0; v < 2; v++)
          runEvent(1'b1, 1'b0, 12'h0, 1'b1, v[0], 12'h320 + 12'(b*4 + sl*2 + v),
                   (b != 0) ? 32'h1000_0050 : 32'h4000_0050, 32'h0C00_2000,
                   32'h0CFF_E000, sl[0], 1'b0, (b != 0) ? "R5" : "R9");

    // R9: mask output follows SR bits 7:4 for each value
    for (int m = 0; m < 16; m++)
      runEvent(1'b1, 1'b0, 12'h0, 1'b1, 1'b1, 12'h200 + 12'(m),
               {24'h0, m[3:0], 4'h0}, 32'h0C00_3000, 32'h0CFF_D000, 1'b0,
               m[0], "R9");

    // R2: both requested, exception wins, INTEVT kept
    runEvent(1'b1, 1'b1, 12'h180, 1'b1, 1'b1, 12'h5A0, 32'h0, 32'h0C00_4000,
             32'h1, 1'b0, 1'b0, "R2");
    runEvent(1'b1, 1'b1, 12'h040, 1'b1, 1'b1, 12'h7E0, 32'h0, 32'h0C00_4100,
             32'h2, 1'b0, 1'b1, "R2");

    // R10: no strobe, nothing changes; strobe without request, nothing changes
    runEvent(1'b0, 1'b1, 12'h0E0, 1'b1, 1'b1, 12'h111, 32'h0, 32'h0C00_5000,
             32'h3, 1'b0, 1'b0, "R10");
    runEvent(1'b1, 1'b0, 12'h0E0, 1'b0, 1'b1, 12'h111, 32'h0, 32'h0C00_5000,
             32'h3, 1'b0, 1'b0, "R10");
    // R10: done is a single-cycle pulse
    runEvent(1'b1, 1'b1, 12'h0E0, 1'b0, 1'b0, 12'h0, 32'h0, 32'h0C00_6000,
             32'h4, 1'b0, 1'b0, "R10");
    @(negedge clk);
    chk(entryDone == 1'b0, "R10", "done pulse width", {31'h0, entryDone}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule